// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block controls a bank of general-purpose pins from a word-addressed register bus. Software sets direction, output level, pull-up and drive strength for each pin and reads back the synchronised pad levels. The pad-facing side is modelled as plain input, output-value and output-enable vectors. Each pin can also be handed to one of two alternate peripheral functions, which then drive its output value and output enable.

Every pin senses four trigger kinds on its synchronised input: rising edge, falling edge, high level and low level. Each kind has its own enable register and its own pending register, and pending bits are cleared by writing ones. A pin's interrupt line is high while any trigger kind has both its pending bit and its enable bit set. That line goes to an external interrupt controller.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset every writable register and every pending bit is 0, so `pad_out`, `pad_oe` and `pin_irq` are all 0.
- R2: Writable registers read back what was written. Byte offsets are: sense enable 0x04, drive enable 0x08, drive value 0x0C, pull-up 0x10, strength 0x14, alternate enable 0x38 and alternate select 0x3C. Pull-up and strength appear on `pad_pue` and `pad_ds`.
- R3: Offset 0x00 returns the pad level after two synchronising flops, ANDed with the sense-enable bit. A pad change driven before clock edge k is visible after edge k+1.
- R4: A 0-to-1 change of the sensed level sets the rise pending bit (offset 0x1C) one edge after it becomes visible at 0x00, whatever the rise enable (0x18) holds.
- R5: A 1-to-0 change of the sensed level of an enabled pin sets the fall pending bit (offset 0x24; enable at 0x20).
- R6: A sensed high level sets the high pending bit (0x2C; enable 0x28) on every cycle it lasts. A low pad level on a pin with sense enable set sets the low pending bit (0x34; enable 0x30) in the same way.
- R7: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. When a set condition and a clearing write hit the same cycle, the bit stays set.
- R8: `pin_irq[i]` is the OR, over the four trigger kinds, of pending AND enable for pin i. It stays high for as long as such a pair stays set.
- R9: With alternate enable 0 a pin drives the drive-value and drive-enable registers. With alternate enable 1, a select bit of 0 picks `alt0_out`/`alt0_oe` and a select bit of 1 picks `alt1_out`/`alt1_oe`.
- R10: Reads of offsets outside the map (above 0x3C or not word-aligned) return 0, and writes to them change nothing. Writes to offset 0x00 change nothing.
- R11: A pin whose sense-enable bit is 0 sets none of its four pending bits, whatever its pad does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_addr | input | ADDR_W (8) | Byte offset for reads and writes |
| bus_wdata | input | NPIN (32) | Write data |
| bus_rdata | output | NPIN (32) | Read data for `bus_addr`, combinational |
| pad_in | input | NPIN | Asynchronous pad levels |
| pad_out | output | NPIN | Pad output values |
| pad_oe | output | NPIN | Pad output enables |
| pad_pue | output | NPIN | Pad pull-up enables |
| pad_ds | output | NPIN | Pad drive-strength selects |
| alt0_out | input | NPIN | Alternate function 0 output values |
| alt0_oe | input | NPIN | Alternate function 0 output enables |
| alt1_out | input | NPIN | Alternate function 1 output values |
| alt1_oe | input | NPIN | Alternate function 1 output enables |
| pin_irq | output | NPIN | Per-pin interrupt lines |

## Verification
The pads are driven first high with sensing off, which separates gating from detection, and then low with sensing on, which shows level sensing and set-over-clear. Next a two-pin 0-to-1 step is applied and sampled one cycle before and one cycle on the pending edge, which pins down the synchroniser latency and separates the edge kinds from the level kinds. A later 1-to-0 step on one pin, with the other pin held high, separates fall from high and shows clearing while a level persists. Selective alternate-function patterns with a mixed select word show that each pin picks its own source.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NTRIG = 4;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_LOW  = 2'd3
    } trig_e;

    localparam logic [7:0] OFF_PIN_LVL  = 8'h00;
    localparam logic [7:0] OFF_SENSE_EN = 8'h04;
    localparam logic [7:0] OFF_DRV_EN   = 8'h08;
    localparam logic [7:0] OFF_DRV_VAL  = 8'h0C;
    localparam logic [7:0] OFF_PULLUP   = 8'h10;
    localparam logic [7:0] OFF_STRENGTH = 8'h14;
    localparam logic [7:0] OFF_ALT_EN   = 8'h38;
    localparam logic [7:0] OFF_ALT_SEL  = 8'h3C;

    // enable/pending pairs are spaced 8 bytes apart, starting at 0x18
    function automatic logic [7:0] trig_ie_off(input trig_e k);
        return 8'h18 + {3'b000, k, 3'b000};
    endfunction

    function automatic logic [7:0] trig_ip_off(input trig_e k);
        return 8'h1C + {3'b000, k, 3'b000};
    endfunction

    function automatic logic off_mapped(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a <= OFF_ALT_SEL);
    endfunction

endpackage

// File: rtl/gpio_in_sense.sv
module gpio_in_sense
    import gpio_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPIN-1:0]             pad_in,
    input  logic [NPIN-1:0]             sense_en,
    output logic [NPIN-1:0]             lvl,
    output logic [NTRIG-1:0][NPIN-1:0]  hit
);
    logic [NPIN-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= lvl;
        end
    end

    assign lvl = sync_q & sense_en;

    always_comb begin
        hit[TRIG_RISE] = lvl & ~prev_q;
        hit[TRIG_FALL] = sense_en & prev_q & ~sync_q;
        hit[TRIG_HIGH] = lvl;
        hit[TRIG_LOW]  = sense_en & ~sync_q;
    end
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] set_v,
    input  logic [NPIN-1:0] clr_v,
    output logic [NPIN-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_v) | set_v;   // set beats clear
    end
endmodule

// File: rtl/gpio_alt_mux.sv
module gpio_alt_mux #(
    parameter int NPIN = 32
) (
    input  logic [NPIN-1:0] alt_en,
    input  logic [NPIN-1:0] alt_sel,
    input  logic [NPIN-1:0] gp_out,
    input  logic [NPIN-1:0] gp_oe,
    input  logic [NPIN-1:0] f0_out,
    input  logic [NPIN-1:0] f0_oe,
    input  logic [NPIN-1:0] f1_out,
    input  logic [NPIN-1:0] f1_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_comb begin
            if (!alt_en[i]) begin
                pad_out[i] = gp_out[i];
                pad_oe[i]  = gp_oe[i];
            end else if (alt_sel[i]) begin
                pad_out[i] = f1_out[i];
                pad_oe[i]  = f1_oe[i];
            end else begin
                pad_out[i] = f0_out[i];
                pad_oe[i]  = f0_oe[i];
            end
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_pue,
    output logic [NPIN-1:0]   pad_ds,
    input  logic [NPIN-1:0]   alt0_out,
    input  logic [NPIN-1:0]   alt0_oe,
    input  logic [NPIN-1:0]   alt1_out,
    input  logic [NPIN-1:0]   alt1_oe,
    output logic [NPIN-1:0]   pin_irq
);
    logic [7:0] addr8;
    logic       hi_zero;
    logic       wr_ok;

    assign addr8   = bus_addr[7:0];
    assign hi_zero = ((bus_addr >> 8) == '0);
    assign wr_ok   = bus_wr && hi_zero;

    logic [NPIN-1:0] sense_en_q, drv_en_q, drv_val_q, pullup_q, strength_q;
    logic [NPIN-1:0] alt_en_q, alt_sel_q;
    logic [NPIN-1:0] lvl;
    logic [NTRIG-1:0][NPIN-1:0] hit, ie_q, ip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_en_q <= '0;
            drv_en_q   <= '0;
            drv_val_q  <= '0;
            pullup_q   <= '0;
            strength_q <= '0;
            alt_en_q   <= '0;
            alt_sel_q  <= '0;
        end else if (wr_ok) begin
            case (addr8)
                OFF_SENSE_EN: sense_en_q <= bus_wdata;
                OFF_DRV_EN:   drv_en_q   <= bus_wdata;
                OFF_DRV_VAL:  drv_val_q  <= bus_wdata;
                OFF_PULLUP:   pullup_q   <= bus_wdata;
                OFF_STRENGTH: strength_q <= bus_wdata;
                OFF_ALT_EN:   alt_en_q   <= bus_wdata;
                OFF_ALT_SEL:  alt_sel_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    gpio_in_sense #(.NPIN(NPIN)) u_sense (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .sense_en (sense_en_q),
        .lvl      (lvl),
        .hit      (hit)
    );

    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
        logic ie_sel, ip_sel;
        assign ie_sel = wr_ok && (addr8 == trig_ie_off(trig_e'(t)));
        assign ip_sel = wr_ok && (addr8 == trig_ip_off(trig_e'(t)));

        always_ff @(posedge clk) begin
            if (rst)         ie_q[t] <= '0;
            else if (ie_sel) ie_q[t] <= bus_wdata;
        end

        gpio_pend_bank #(.NPIN(NPIN)) u_pend (
            .clk   (clk),
            .rst   (rst),
            .set_v (hit[t]),
            .clr_v (ip_sel ? bus_wdata : '0),
            .pend  (ip_q[t])
        );
    end

    always_comb begin
        pin_irq = '0;
        for (int t = 0; t < NTRIG; t++) pin_irq = pin_irq | (ip_q[t] & ie_q[t]);
    end

    always_comb begin
        bus_rdata = '0;
        if (hi_zero) begin
            case (addr8)
                OFF_PIN_LVL:  bus_rdata = lvl;
                OFF_SENSE_EN: bus_rdata = sense_en_q;
                OFF_DRV_EN:   bus_rdata = drv_en_q;
                OFF_DRV_VAL:  bus_rdata = drv_val_q;
                OFF_PULLUP:   bus_rdata = pullup_q;
                OFF_STRENGTH: bus_rdata = strength_q;
                OFF_ALT_EN:   bus_rdata = alt_en_q;
                OFF_ALT_SEL:  bus_rdata = alt_sel_q;
                default: ;
            endcase
            for (int t = 0; t < NTRIG; t++) begin
                if (addr8 == trig_ie_off(trig_e'(t))) bus_rdata = ie_q[t];
                if (addr8 == trig_ip_off(trig_e'(t))) bus_rdata = ip_q[t];
            end
        end
    end

    gpio_alt_mux #(.NPIN(NPIN)) u_mux (
        .alt_en  (alt_en_q),
        .alt_sel (alt_sel_q),
        .gp_out  (drv_val_q),
        .gp_oe   (drv_en_q),
        .f0_out  (alt0_out),
        .f0_oe   (alt0_oe),
        .f1_out  (alt1_out),
        .f1_oe   (alt1_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign pad_pue = pullup_q;
    assign pad_ds  = strength_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [NPIN-1:0]            bus_rdata,
    input logic [NPIN-1:0]            pin_irq,
    input logic [NPIN-1:0]            pad_out,
    input logic [NPIN-1:0]            drv_val_q,
    input logic [NPIN-1:0]            alt_en_q,
    input logic [NPIN-1:0]            sense_en_q,
    input logic [NTRIG-1:0][NPIN-1:0] ie_q,
    input logic [NTRIG-1:0][NPIN-1:0] ip_q
);
    logic             in_map;
    logic [NPIN-1:0]  any_ie;

    assign in_map = ((bus_addr >> 8) == '0) && off_mapped(bus_addr[7:0]);
    assign any_ie = ie_q[0] | ie_q[1] | ie_q[2] | ie_q[3];

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !in_map |-> (bus_rdata == '0));

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (pin_irq & ~any_ie) == '0);

    assert_gpio_path_R9: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~alt_en_q) == (drv_val_q & ~alt_en_q));

    for (genvar t = 0; t < NTRIG; t++) begin : g_chk
        assert_pend_only_w1c_R7: assert property (@(posedge clk) disable iff (rst)
            !(bus_wr && (bus_addr == ADDR_W'(trig_ip_off(trig_e'(t)))))
            |=> (($past(ip_q[t]) & ~ip_q[t]) == '0));

        assert_no_sense_no_set_R11: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ((ip_q[t] & ~$past(ip_q[t]) & ~$past(sense_en_q)) == '0));
    end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .pin_irq    (pin_irq),
    .pad_out    (pad_out),
    .drv_val_q  (drv_val_q),
    .alt_en_q   (alt_en_q),
    .sense_en_q (sense_en_q),
    .ie_q       (ie_q),
    .ip_q       (ip_q)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] pad_in, pad_out, pad_oe, pad_pue, pad_ds;
    logic [31:0] alt0_out, alt0_oe, alt1_out, alt1_oe, pin_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NPIN(32), .ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pue(pad_pue), .pad_ds(pad_ds),
        .alt0_out(alt0_out), .alt0_oe(alt0_oe), .alt1_out(alt1_out),
        .alt1_oe(alt1_oe), .pin_irq(pin_irq)
    );

    // {offset, write data, expected read-back}
    localparam int NVEC = 9;
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h08, 32'hA5A5F00F, 32'hA5A5F00F},   // R2
        {8'h0C, 32'h12345678, 32'h12345678},   // R2
        {8'h10, 32'hFFFF0000, 32'hFFFF0000},   // R2
        {8'h14, 32'h0F0F0F0F, 32'h0F0F0F0F},   // R2
        {8'h3C, 32'hCAFEBABE, 32'hCAFEBABE},   // R2
        {8'h04, 32'h00000000, 32'h00000000},   // R2
        {8'h40, 32'hFFFFFFFF, 32'h00000000},   // R10 unmapped
        {8'h1C, 32'hFFFFFFFF, 32'h00000000},   // R7 clear of empty pending
        {8'h00, 32'hFFFFFFFF, 32'h00000000}    // R10 level register not writable
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pad_in = '0; alt0_out = '0; alt0_oe = '0; alt1_out = '0; alt1_oe = '0;
        cyc(3);
        rst = 1'b0;

        // R1 reset state
        rd(8'h08, d); chk(d, 32'h0, "R1 drive enable after reset");
        rd(8'h1C, d); chk(d, 32'h0, "R1 rise pending after reset");
        chk(pin_irq, 32'h0, "R1 irq after reset");
        chk(pad_oe,  32'h0, "R1 pad_oe after reset");
        chk(pad_out, 32'h0, "R1 pad_out after reset");

        // table walk: write then read back
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], d);
            chk(d, VEC[i][31:0], $sformatf("R2/R10 table entry %0d", i));
        end
        chk(pad_pue, 32'hFFFF0000, "R2 pad_pue");
        chk(pad_ds,  32'h0F0F0F0F, "R2 pad_ds");

        // R11: sensing off, pads high
        pad_in = 32'hFFFFFFFF;
        cyc(4);
        rd(8'h1C, d); chk(d, 32'h0, "R11 rise pending with sensing off");
        rd(8'h2C, d); chk(d, 32'h0, "R11 high pending with sensing off");
        rd(8'h00, d); chk(d, 32'h0, "R3 level reads 0 with sensing off");

        // pads low, then enable sensing: low level sets pending
        pad_in = 32'h0;
        cyc(3);
        wr(8'h04, 32'hFFFFFFFF);
        cyc(2);
        rd(8'h34, d); chk(d, 32'hFFFFFFFF, "R6 low pending set");
        rd(8'h24, d); chk(d, 32'h0, "R5 no fall on enabling sensing");
        wr(8'h34, 32'hFFFFFFFF);
        rd(8'h34, d); chk(d, 32'hFFFFFFFF, "R7 set wins over clear");

        // rising step on pins 0 and 1
        pad_in = 32'h00000003;
        cyc(2);
        rd(8'h00, d); chk(d, 32'h3, "R3 level after two edges");
        rd(8'h1C, d); chk(d, 32'h0, "R4 rise pending not yet set");
        cyc(1);
        rd(8'h1C, d); chk(d, 32'h3, "R4 rise pending set");
        rd(8'h2C, d); chk(d, 32'h3, "R6 high pending set");
        chk(pin_irq, 32'h0, "R8 no irq without enables");

        wr(8'h18, 32'h00000001);
        chk(pin_irq, 32'h1, "R8 irq with rise enable");
        cyc(3);
        chk(pin_irq, 32'h1, "R8 irq held while pending");

        wr(8'h1C, 32'h0);
        rd(8'h1C, d); chk(d, 32'h3, "R7 writing 0 keeps pending");
        wr(8'h1C, 32'h1);
        rd(8'h1C, d); chk(d, 32'h2, "R7 writing 1 clears pending");
        chk(pin_irq, 32'h0, "R8 irq drops after clear");

        // falling step on pin 0, pin 1 stays high
        pad_in = 32'h00000002;
        cyc(3);
        rd(8'h24, d); chk(d, 32'h1, "R5 fall pending set");
        wr(8'h2C, 32'hFFFFFFFF);
        rd(8'h2C, d); chk(d, 32'h2, "R6/R7 high pending kept only where level persists");

        // R9 alternate functions
        alt0_out = 32'h00000050; alt0_oe = 32'hFFFFFFFF;
        alt1_out = 32'h000000A0; alt1_oe = 32'h0;
        wr(8'h38, 32'h000000F0);
        chk(pad_out, 32'h123456E8, "R9 pad_out with alternate functions");
        chk(pad_oe,  32'hA5A5F04F, "R9 pad_oe with alternate functions");

        // R10 unmapped write ignored
        wr(8'h44, 32'hFFFFFFFF);
        rd(8'h44, d); chk(d, 32'h0, "R10 unmapped read");
        rd(8'h38, d); chk(d, 32'h000000F0, "R10 unmapped write left map intact");
        rd(8'h3A, d); chk(d, 32'h0, "R10 misaligned read");

        finish_run();
    end
endmodule